// File: doc/BRIEF.md
# RGB to CMYK Pixel Converter

This block turns a stream of RGB pixels, one per clock, into the four process-ink values cyan, magenta, yellow and black. Each colour channel is first inverted against full scale. The smallest of the three inverted channels becomes the black value. That black value is then taken away from each inverted channel to give the remaining ink. This is more than a per-channel inversion: the common grey part of a pixel moves entirely into black. As a result, the three coloured inks never all carry a non-zero amount at once.

The interface is a plain strobe stream with no back-pressure. A pixel is presented with `in_valid` high. Its result appears on the outputs together with `out_valid` exactly three clock cycles later. A new pixel may be accepted on every cycle. The pipeline has three register stages: inversion, minimum selection, and subtraction. Each stage loads only on a valid beat, so the outputs keep the last result during gaps in the stream.

Top module: `rgb2cmyk_conv`

## Requirements
- R1: Each inverted channel equals 255 minus the input channel. The red input maps to cyan, green to magenta and blue to yellow.
- R2: `out_black` equals the smallest of the three inverted channels of the same pixel.
- R3: `out_cyan`, `out_magenta` and `out_yellow` each equal their inverted channel minus `out_black` of the same pixel.
- R4: Whenever `out_valid` is high, at least one of `out_cyan`, `out_magenta` and `out_yellow` is zero.
- R5: `out_valid` is `in_valid` delayed by exactly 3 clock cycles, and the results appear in the same cycle as `out_valid`.
- R6: While `rst_n` is low at a rising clock edge, `out_valid` and all four colour outputs go to 0 after that edge. The reset is synchronous and active low.
- R7: Pixels presented on consecutive cycles produce results on consecutive cycles, in the order they were presented.
- R8: The subtraction never underflows, because black never exceeds any inverted channel of the same pixel. No output wraps around.
- R9: A cycle with `in_valid` low does not change the colour outputs. After a gap in the stream, the outputs keep the last delivered result, or the reset value of 0 if nothing has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Pixel on the RGB inputs is valid this cycle |
| in_red | input | 8 | Red channel, 0 to 255 |
| in_green | input | 8 | Green channel, 0 to 255 |
| in_blue | input | 8 | Blue channel, 0 to 255 |
| out_valid | output | 1 | Result on the CMYK outputs is valid this cycle |
| out_cyan | output | 8 | Cyan ink, 0 to 255 |
| out_magenta | output | 8 | Magenta ink, 0 to 255 |
| out_yellow | output | 8 | Yellow ink, 0 to 255 |
| out_black | output | 8 | Black ink, 0 to 255 |

## Verification
The stimulus starts with the fixed corners. Pure black input gives full black ink and no colour. Pure white gives all zeros. The three pure primaries each give a single zero colour channel and saturated others. Together these separate an inverted-channel mapping from a swapped one. Equal-channel greys and pixels whose minimum lies in a different channel each time show whether the minimum is chosen from the right input, including ties. A long back-to-back run of pseudo-random pixels, with random gaps, exposes ordering, latency and hold faults that single pixels would not.

// File: rtl/rgbk_pkg.sv
// Shared constants for the RGB to CMYK converter.
// Assumes three colour channels of equal width.
package rgbk_pkg;
    localparam int CHAN_W  = 8;
    localparam int N_CHAN  = 3;
    localparam int LATENCY = 3;
endpackage

// File: rtl/rgbk_invert.sv
// Stage 1: inverts every channel against full scale (all ones).
// Assumes channels are unsigned; loads only on a valid beat.
module rgbk_invert #(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [N-1:0][W-1:0] in_chan,
    output logic                out_valid,
    output logic [N-1:0][W-1:0] out_comp
);
    localparam logic [W-1:0] FULL = '1;

    // Valid bit follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    for (genvar i = 0; i < N; i++) begin : g_inv
        // Registers the inverted value of channel i.
        always_ff @(posedge clk) begin
            if (!rst_n)        out_comp[i] <= '0;
            else if (in_valid) out_comp[i] <= FULL - in_chan[i];
        end

        // R1: inverted value and the source channel add up to full scale.
        a_r1_complement: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> ({1'b0, out_comp[i]} + {1'b0, $past(in_chan[i])}) == {1'b0, FULL});
    end
endmodule

// File: rtl/rgbk_minsel.sv
// Stage 2: picks the smallest inverted channel as black and
// forwards the inverted channels alongside it.
module rgbk_minsel #(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [N-1:0][W-1:0] in_comp,
    output logic                out_valid,
    output logic [N-1:0][W-1:0] out_comp,
    output logic [W-1:0]        out_black
);
    logic [W-1:0] min_c;
    logic [N-1:0] hit;

    // Linear scan for the minimum of the inverted channels.
    always_comb begin
        min_c = in_comp[0];
        for (int i = 1; i < N; i++) begin
            if (in_comp[i] < min_c) min_c = in_comp[i];
        end
    end

    // Registers the valid bit, the forwarded channels and black.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_comp  <= '0;
            out_black <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_comp  <= in_comp;
                out_black <= min_c;
            end
        end
    end

    // Marks which forwarded channels equal black (assertion support).
    always_comb begin
        for (int i = 0; i < N; i++) hit[i] = (out_black == out_comp[i]);
    end

    // R2: black is one of the channels of the same pixel.
    a_r2_black_member: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (|hit));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R2: black does not exceed any channel.
        a_r2_black_min: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_black <= out_comp[i]);
    end
endmodule

// File: rtl/rgbk_subtract.sv
// Stage 3: removes black from each inverted channel.
// Assumes the incoming black never exceeds any channel.
module rgbk_subtract #(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [N-1:0][W-1:0] in_comp,
    input  logic [W-1:0]        in_black,
    output logic                out_valid,
    output logic [N-1:0][W-1:0] out_ink,
    output logic [W-1:0]        out_black
);
    logic [N-1:0] ink_zero;

    // Valid bit and black pass through one register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_black <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_black <= in_black;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_sub
        // Registers channel i minus black.
        always_ff @(posedge clk) begin
            if (!rst_n)        out_ink[i] <= '0;
            else if (in_valid) out_ink[i] <= in_comp[i] - in_black;
        end

        // R8: the subtraction never borrows.
        a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> in_black <= in_comp[i]);
    end

    // Flags zero ink channels (assertion support).
    always_comb begin
        for (int i = 0; i < N; i++) ink_zero[i] = (out_ink[i] == '0);
    end

    // R4: at least one coloured ink is zero on every result.
    a_r4_one_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (|ink_zero));

    // R9: an idle beat leaves the results untouched.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_ink) && $stable(out_black)));
endmodule

// File: rtl/rgb2cmyk_conv.sv
// Top: three-stage RGB to CMYK pipeline (invert, minimum, subtract).
// One pixel per cycle, fixed latency of three cycles, no back-pressure.
module rgb2cmyk_conv #(
    parameter int CW = rgbk_pkg::CHAN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_red,
    input  logic [CW-1:0] in_green,
    input  logic [CW-1:0] in_blue,
    output logic          out_valid,
    output logic [CW-1:0] out_cyan,
    output logic [CW-1:0] out_magenta,
    output logic [CW-1:0] out_yellow,
    output logic [CW-1:0] out_black
);
    localparam int NC = rgbk_pkg::N_CHAN;

    logic [NC-1:0][CW-1:0] chan, comp1, comp2, ink;
    logic                  v1, v2;
    logic [CW-1:0]         blk2;
    logic [1:0]            age;

    // Gathers the channels; index 0 red, 1 green, 2 blue.
    always_comb begin
        chan[0] = in_red;
        chan[1] = in_green;
        chan[2] = in_blue;
    end

    rgbk_invert #(.W(CW), .N(NC)) u_inv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(chan),
        .out_valid(v1), .out_comp(comp1)
    );

    rgbk_minsel #(.W(CW), .N(NC)) u_min (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_comp(comp1),
        .out_valid(v2), .out_comp(comp2), .out_black(blk2)
    );

    rgbk_subtract #(.W(CW), .N(NC)) u_sub (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_comp(comp2),
        .in_black(blk2), .out_valid(out_valid), .out_ink(ink),
        .out_black(out_black)
    );

    // Maps ink channels to the named outputs.
    always_comb begin
        out_cyan    = ink[0];
        out_magenta = ink[1];
        out_yellow  = ink[2];
    end

    // Counts cycles since reset, saturating at the latency (assertion support).
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 2'd1;
    end

    // R5: the output strobe is the input strobe three cycles late.
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3) |-> out_valid == $past(in_valid, 3));

    // R6: reset clears the strobe and all outputs.
    a_r6_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_cyan == '0 && out_magenta == '0 &&
                    out_yellow == '0 && out_black == '0));
endmodule

// File: tb/rgb2cmyk_conv_test.sv
module rgb2cmyk_conv_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_red = '0, in_green = '0, in_blue = '0;
    logic       out_valid;
    logic [7:0] out_cyan, out_magenta, out_yellow, out_black;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] last_exp = '0;
    logic [2:0]  vhist = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb2cmyk_conv uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
        .out_valid(out_valid), .out_cyan(out_cyan), .out_magenta(out_magenta),
        .out_yellow(out_yellow), .out_black(out_black)
    );

    // Reference from the requirements: packs {C, M, Y, K}.
    function automatic logic [31:0] ref_cmyk(input logic [7:0] r, g, b);
        logic [7:0] c, m, y, k;
        c = 8'd255 - r; m = 8'd255 - g; y = 8'd255 - b;
        k = c;
        if (m < k) k = m;
        if (y < k) k = y;
        return {c - k, m - k, y - k, k};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: presents one pixel (or an idle beat) and queues its result.
    task automatic drive(input bit v, input logic [7:0] r, g, b);
        @(negedge clk);
        in_valid = v; in_red = r; in_green = g; in_blue = b;
        if (v) exp_q.push_back(ref_cmyk(r, g, b));
    endtask

    // Monitor: compares results, strobe timing and idle hold.
    always @(negedge clk) begin
        logic [31:0] act, exp;
        if (rst_n && !done) begin
            act = {out_cyan, out_magenta, out_yellow, out_black};
            check(out_valid == vhist[2], "R5 strobe latency", {31'd0, out_valid}, {31'd0, vhist[2]});
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", act, 32'd0);
                end else begin
                    exp = exp_q.pop_front();
                    check(act == exp, "R1 R2 R3 R7 pixel result", act, exp);
                    check(out_cyan == 0 || out_magenta == 0 || out_yellow == 0,
                          "R4 one ink zero", act, exp);
                    check({1'b0, out_cyan} + {1'b0, out_black} <= 9'd255,
                          "R8 no underflow", act, exp);
                    last_exp = exp;
                end
            end else begin
                check(act == last_exp, "R9 hold on idle", act, last_exp);
            end
        end
    end

    // Bench-side strobe history, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) vhist <= '0;
        else        vhist <= {vhist[1:0], in_valid};
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R6: outputs cleared while in reset.
        check(!out_valid && out_cyan == 0 && out_magenta == 0 && out_yellow == 0 && out_black == 0,
              "R6 reset state", {out_cyan, out_magenta, out_yellow, out_black}, 32'd0);
        rst_n = 1'b1;
        drive(0, 0, 0, 0);
        // Corners.
        drive(1, 8'd0,   8'd0,   8'd0);     // black -> K=255
        drive(1, 8'd255, 8'd255, 8'd255);   // white -> all zero
        drive(1, 8'd255, 8'd0,   8'd0);     // red
        drive(1, 8'd0,   8'd255, 8'd0);     // green
        drive(1, 8'd0,   8'd0,   8'd255);   // blue
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        // Greys and ties, minimum in each channel.
        drive(1, 8'd128, 8'd128, 8'd128);
        drive(1, 8'd200, 8'd10,  8'd50);
        drive(1, 8'd10,  8'd200, 8'd50);
        drive(1, 8'd10,  8'd50,  8'd200);
        drive(1, 8'd90,  8'd90,  8'd20);
        drive(0, 0, 0, 0);
        drive(1, 8'd1,   8'd254, 8'd254);
        // Random stream with gaps.
        for (int i = 0; i < 2000; i++) begin
            rv = $urandom;
            drive(rv[31:29] != 0, rv[7:0], rv[15:8], rv[23:16]);
        end
        drive(0, 0, 0, 0);
        repeat (6) drive(0, 0, 0, 0);
        check(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 32'd0);
        // R6: reset mid-stream clears outputs.
        drive(1, 8'd3, 8'd4, 8'd5);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        exp_q.delete();
        @(negedge clk);
        check(!out_valid && {out_cyan, out_magenta, out_yellow, out_black} == 0,
              "R6 reset mid-run", {out_cyan, out_magenta, out_yellow, out_black}, 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule